// File: doc/BRIEF.md
# Receive Sampling Tap Tuning Sequencer

This block searches for the best receive sampling delay on a high-speed (HS200) card link. After a start pulse it walks a tap code upward from zero through a fixed search range. Each candidate is presented on a tap bus and held with an apply strobe until the delay line acknowledges that the tap has taken effect. Only then is an external checker asked whether a tuning transfer at that tap succeeded. A tap that cannot be applied, or that the checker rejects, breaks the current run of good taps.

Once the range is covered, the engine applies the tap at the middle of the longest unbroken run of good taps and pulses done. If no tap was good, or the final tap cannot be applied, it raises an error flag instead. The flag stays up until the next search starts. Building the tuning command and comparing its data pattern are left to the checker.

Top module: `tap_tune_engine`

## Requirements
- R1: A search presents the taps 0, 1, 2 ... TAP_LIMIT-1 (default 40) in ascending order, each exactly once. No code at or above TAP_LIMIT is ever presented, although the tap bus is TAP_W (default 6) bits wide.
- R2: `tap_apply_o` rises together with a new `tap_o` value. It stays high with `tap_o` unchanged until `tap_ready_i` is sampled high, and it drops on the following clock edge.
- R3: If `tap_ready_i` is not seen within APPLY_TIMEOUT (default 16) cycles of the apply strobe rising, the strobe drops. That tap counts as failing and produces no checker request. A ready arriving in the last allowed cycle still counts as applied.
- R4: `chk_req_o` is raised only after the tap has been applied, never while `tap_apply_o` is high. It is held until `chk_ack_i` is sampled, and `chk_pass_i` is read in that same cycle.
- R5: A good tap (applied and passed) extends the current run by one, and any bad tap resets it to zero. The recorded best run and its last tap change only when the current run becomes strictly longer, so among runs of equal length the earliest one wins.
- R6: After the last tap, the engine applies the tap equal to the last tap of the best run minus half the run length, rounded down.
- R7: If no tap in the range was good, `err_o` rises and no final tap is applied.
- R8: `done_o` is high for exactly one cycle, after the final tap has been applied. It is never high together with `err_o`.
- R9: `err_o` stays high until the next accepted start and is cleared by it.
- R10: A start pulse while a search is running is ignored, and the sweep continues unchanged.
- R11: Out of reset, `tap_apply_o`, `chk_req_o`, `done_o` and `err_o` are low.
- R12: If the final tap is not acknowledged within APPLY_TIMEOUT cycles, `err_o` rises and `done_o` does not pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a search when idle |
| tap_o | output | TAP_W | Tap code presented to the delay line |
| tap_apply_o | output | 1 | Update strobe, held until the tap takes effect |
| tap_ready_i | input | 1 | Delay line reports the tap is in effect |
| chk_req_o | output | 1 | Request a pass/fail verdict for the current tap |
| chk_ack_i | input | 1 | Verdict valid |
| chk_pass_i | input | 1 | Verdict: tap is good |
| done_o | output | 1 | One-cycle pulse: best tap applied |
| err_o | output | 1 | Search failed; held until next start |

## Verification
Some properties are checked on every cycle: the tap bus stays stable while the strobe is held, no code at or above the limit is presented, the strobe never exceeds its timeout window, the checker handshake is held and never overlaps an apply, done is a single-cycle pulse, and error is sticky. Other behaviour can only be shown by the bench scenarios. These cover which tap is finally chosen, tie-breaking between equal runs, the exact timeout boundary, the no-pass and final-timeout error paths, and a start pulse ignored mid-sweep. The bench compares all of these against a streak model over directed and seeded random pass/latency patterns.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LAUNCH,
      ST_WAIT_AP,
      ST_CHECK,
      ST_STEP,
      ST_FLAUNCH,
      ST_FWAIT
   } tune_st_e;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tap_apply_ctl.sv
module tap_apply_ctl #(
   parameter int TAP_W         = 6,
   parameter int APPLY_TIMEOUT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [TAP_W:0]   val_i,
   input  logic             ready_i,
   output logic [TAP_W-1:0] tap_o,
   output logic             apply_o,
   output logic             fin_o,
   output logic             ok_o
);
   import tap_tune_pkg::*;

   localparam int          CNT_W = cnt_width(APPLY_TIMEOUT);
   localparam logic [TAP_W:0] MAX_CODE = {1'b0, {TAP_W{1'b1}}};

   logic tmo_hit;

   generate
      if (APPLY_TIMEOUT > 0) begin : g_timeout
         logic [CNT_W-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          wait_cnt <= '0;
            else if (!apply_o)   wait_cnt <= '0;
            else                 wait_cnt <= wait_cnt + 1'b1;
         end
         assign tmo_hit = apply_o && (wait_cnt == CNT_W'(APPLY_TIMEOUT - 1));
      end else begin : g_no_timeout
         assign tmo_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_o   <= '0;
         apply_o <= 1'b0;
         fin_o   <= 1'b0;
         ok_o    <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            if (val_i > MAX_CODE) begin
               fin_o <= 1'b1;
               ok_o  <= 1'b0;
            end else begin
               tap_o   <= val_i[TAP_W-1:0];
               apply_o <= 1'b1;
            end
         end else if (apply_o) begin
            if (ready_i) begin
               apply_o <= 1'b0;
               fin_o   <= 1'b1;
               ok_o    <= 1'b1;
            end else if (tmo_hit) begin
               apply_o <= 1'b0;
               fin_o   <= 1'b1;
               ok_o    <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/tap_streak_track.sv
module tap_streak_track #(
   parameter int TAP_W     = 6,
   parameter int TAP_LIMIT = 40
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr_i,
   input  logic                          upd_i,
   input  logic                          good_i,
   input  logic [TAP_W-1:0]              idx_i,
   output logic [$clog2(TAP_LIMIT+1)-1:0] best_o,
   output logic [TAP_W-1:0]              end_o
);
   localparam int SW = $clog2(TAP_LIMIT + 1);

   logic [SW-1:0] run_q;
   logic [SW-1:0] run_nx;

   assign run_nx = run_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         best_o <= '0;
         end_o  <= '0;
      end else if (clr_i) begin
         run_q  <= '0;
         best_o <= '0;
         end_o  <= '0;
      end else if (upd_i) begin
         if (!good_i) begin
            run_q <= '0;
         end else begin
            run_q <= run_nx;
            if (run_nx > best_o) begin
               best_o <= run_nx;
               end_o  <= idx_i;
            end
         end
      end
   end

endmodule

// File: rtl/tap_tune_engine.sv
module tap_tune_engine #(
   parameter int TAP_W         = 6,
   parameter int TAP_LIMIT     = 40,
   parameter int APPLY_TIMEOUT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic [TAP_W-1:0] tap_o,
   output logic             tap_apply_o,
   input  logic             tap_ready_i,
   output logic             chk_req_o,
   input  logic             chk_ack_i,
   input  logic             chk_pass_i,
   output logic             done_o,
   output logic             err_o
);
   import tap_tune_pkg::*;

   localparam int              SW       = $clog2(TAP_LIMIT + 1);
   localparam logic [TAP_W-1:0] LAST_IDX = TAP_W'(TAP_LIMIT - 1);

   generate
      if (TAP_W < 1 || TAP_W > 8) begin : g_bad_width
         $error("tap_tune_engine: TAP_W out of range");
      end
      if (TAP_LIMIT < 1 || TAP_LIMIT > (1 << TAP_W)) begin : g_bad_limit
         $error("tap_tune_engine: TAP_LIMIT exceeds tap code space");
      end
      if (APPLY_TIMEOUT < 0) begin : g_bad_tmo
         $error("tap_tune_engine: APPLY_TIMEOUT must not be negative");
      end
   endgenerate

   tune_st_e          st_q;
   logic [TAP_W-1:0]  idx_q;
   logic [SW-1:0]     best_len;
   logic [TAP_W-1:0]  best_end;
   logic [TAP_W:0]    centre;
   logic [TAP_W:0]    ap_val;
   logic              ap_go;
   logic              ap_fin;
   logic              ap_ok;
   logic              trk_clr;
   logic              trk_upd;
   logic              trk_good;

   assign centre = {1'b0, best_end} - (TAP_W+1)'(best_len >> 1);
   assign ap_go  = (st_q == ST_LAUNCH) || (st_q == ST_FLAUNCH);
   assign ap_val = (st_q == ST_FLAUNCH) ? centre : {1'b0, idx_q};

   assign trk_clr  = (st_q == ST_IDLE) && start_i;
   assign trk_upd  = ((st_q == ST_WAIT_AP) && ap_fin && !ap_ok) ||
                     ((st_q == ST_CHECK) && chk_ack_i);
   assign trk_good = (st_q == ST_CHECK) && chk_pass_i;

   assign chk_req_o = (st_q == ST_CHECK);

   tap_apply_ctl #(
      .TAP_W        (TAP_W),
      .APPLY_TIMEOUT(APPLY_TIMEOUT)
   ) u_apply (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (ap_go),
      .val_i  (ap_val),
      .ready_i(tap_ready_i),
      .tap_o  (tap_o),
      .apply_o(tap_apply_o),
      .fin_o  (ap_fin),
      .ok_o   (ap_ok)
   );

   tap_streak_track #(
      .TAP_W    (TAP_W),
      .TAP_LIMIT(TAP_LIMIT)
   ) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (trk_clr),
      .upd_i (trk_upd),
      .good_i(trk_good),
      .idx_i (idx_q),
      .best_o(best_len),
      .end_o (best_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  err_o <= 1'b0;
                  idx_q <= '0;
                  st_q  <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: st_q <= ST_WAIT_AP;
            ST_WAIT_AP: begin
               if (ap_fin) st_q <= ap_ok ? ST_CHECK : ST_STEP;
            end
            ST_CHECK: begin
               if (chk_ack_i) st_q <= ST_STEP;
            end
            ST_STEP: begin
               if (idx_q == LAST_IDX) begin
                  if (best_len == '0) begin
                     err_o <= 1'b1;
                     st_q  <= ST_IDLE;
                  end else begin
                     st_q <= ST_FLAUNCH;
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= ST_LAUNCH;
               end
            end
            ST_FLAUNCH: st_q <= ST_FWAIT;
            ST_FWAIT: begin
               if (ap_fin) begin
                  if (ap_ok) done_o <= 1'b1;
                  else       err_o  <= 1'b1;
                  st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tap_tune_engine_chk.sv
module tap_tune_engine_chk #(
   parameter int TAP_W         = 6,
   parameter int TAP_LIMIT     = 40,
   parameter int APPLY_TIMEOUT = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [TAP_W-1:0] tap_o,
   input logic             tap_apply_o,
   input logic             chk_req_o,
   input logic             chk_ack_i,
   input logic             done_o,
   input logic             err_o
);
   logic [31:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold_cnt <= '0;
      else if (tap_apply_o) hold_cnt <= hold_cnt + 1;
      else                  hold_cnt <= '0;
   end

   p_tap_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tap_apply_o |=> (!tap_apply_o || $stable(tap_o)));

   p_tap_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tap_apply_o |-> (32'(tap_o) < TAP_LIMIT));

   p_apply_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (APPLY_TIMEOUT > 0) |-> (hold_cnt <= APPLY_TIMEOUT));

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req_o && !chk_ack_i) |=> chk_req_o);

   p_req_no_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(chk_req_o && tap_apply_o));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o);

endmodule

bind tap_tune_engine tap_tune_engine_chk #(
   .TAP_W        (TAP_W),
   .TAP_LIMIT    (TAP_LIMIT),
   .APPLY_TIMEOUT(APPLY_TIMEOUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .tap_o      (tap_o),
   .tap_apply_o(tap_apply_o),
   .chk_req_o  (chk_req_o),
   .chk_ack_i  (chk_ack_i),
   .done_o     (done_o),
   .err_o      (err_o)
);

// File: tb/tap_tune_engine_test.sv
module tap_tune_engine_test;
   localparam int TAP_W = 6;
   localparam int LIM   = 40;
   localparam int TMO   = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [TAP_W-1:0] tap_o;
   logic             tap_apply_o;
   logic             tap_ready_i = 1'b0;
   logic             chk_req_o;
   logic             chk_ack_i = 1'b0;
   logic             chk_pass_i = 1'b0;
   logic             done_o;
   logic             err_o;

   int  n_checks = 0;
   int  n_fail   = 0;
   int  cycles   = 0;
   bit  pass_pat [64];
   int  lat_pat  [64];
   bit  final_stall = 1'b0;
   int  resp_n = 0;
   int  tap_log [64];
   int  n_apply = 0;
   int  n_req = 0;
   int  done_cnt = 0;
   bit  prev_apply = 1'b0;
   bit  prev_req = 1'b0;

   always #5 clk = ~clk;

   tap_tune_engine #(.TAP_W(TAP_W), .TAP_LIMIT(LIM), .APPLY_TIMEOUT(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .tap_o(tap_o), .tap_apply_o(tap_apply_o), .tap_ready_i(tap_ready_i),
      .chk_req_o(chk_req_o), .chk_ack_i(chk_ack_i), .chk_pass_i(chk_pass_i),
      .done_o(done_o), .err_o(err_o));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   // observation of the ports, away from the active edge
   always @(negedge clk) begin
      if (tap_apply_o && !prev_apply) begin
         if (n_apply < 64) tap_log[n_apply] = int'(tap_o);
         n_apply++;
      end
      if (chk_req_o && !prev_req) n_req++;
      if (done_o) done_cnt++;
      prev_apply = tap_apply_o;
      prev_req   = chk_req_o;
   end

   // delay-line responder
   initial begin
      forever begin
         @(negedge clk);
         if (tap_apply_o) begin
            int lat;
            bit alive;
            lat = (resp_n == LIM && final_stall) ? TMO + 3 : lat_pat[tap_o];
            resp_n++;
            alive = 1'b1;
            for (int k = 0; k < lat && alive; k++) begin
               @(negedge clk);
               if (!tap_apply_o) alive = 1'b0;
            end
            if (alive && tap_apply_o) begin
               tap_ready_i = 1'b1;
               @(negedge clk);
               tap_ready_i = 1'b0;
            end
            while (tap_apply_o) @(negedge clk);
         end
      end
   end

   // verdict responder
   initial begin
      forever begin
         @(negedge clk);
         if (chk_req_o) begin
            int d;
            d = int'($urandom % 3);
            for (int k = 0; k < d; k++) @(negedge clk);
            chk_pass_i = pass_pat[tap_o];
            chk_ack_i  = 1'b1;
            @(negedge clk);
            chk_ack_i  = 1'b0;
         end
      end
   end

   function automatic void model(output bit e, output int t, output int reqs);
      int cur, best, en;
      cur = 0; best = 0; en = 0; reqs = 0;
      for (int i = 0; i < LIM; i++) begin
         bit applied;
         applied = lat_pat[i] <= TMO - 1;
         if (applied) reqs++;
         if (applied && pass_pat[i]) begin
            cur++;
            if (cur > best) begin best = cur; en = i; end
         end else begin
            cur = 0;
         end
      end
      t = en - best / 2;
      e = (best == 0) || final_stall;
   endfunction

   task automatic run_case(input string name, input bit mid_start);
      bit exp_e;
      int exp_t, exp_req;
      bit was_err, got_end;
      int waited;
      model(exp_e, exp_t, exp_req);
      was_err  = err_o;
      resp_n   = 0;
      n_apply  = 0;
      n_req    = 0;
      done_cnt = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (was_err) check(err_o == 1'b0, "R9", {name, " err cleared by start"}, err_o, 0);
      got_end = 1'b0;
      waited  = 0;
      while (!got_end && waited < 5000) begin
         @(negedge clk);
         waited++;
         if (mid_start && waited == 60) start_i = 1'b1;
         if (mid_start && waited == 61) start_i = 1'b0;
         if (done_o || err_o) got_end = 1'b1;
      end
      check(got_end, "R1", {name, " search ended"}, waited, 0);
      repeat (3) @(negedge clk);
      begin
         bit seq_ok;
         seq_ok = 1'b1;
         for (int i = 0; i < LIM; i++) if (tap_log[i] != i) seq_ok = 1'b0;
         check(seq_ok, mid_start ? "R10" : "R1", {name, " ascending sweep"}, tap_log[1], 1);
      end
      check(n_apply == LIM + (exp_e && !final_stall ? 0 : 1), "R1",
            {name, " apply count"}, n_apply, LIM + (exp_e && !final_stall ? 0 : 1));
      check(n_req == exp_req, "R3", {name, " verdict requests only for applied taps"},
            n_req, exp_req);
      if (exp_e) begin
         check(err_o == 1'b1, final_stall ? "R12" : "R7", {name, " error"}, err_o, 1);
         check(done_cnt == 0, final_stall ? "R12" : "R7", {name, " no done"}, done_cnt, 0);
      end else begin
         check(err_o == 1'b0, "R6", {name, " no error"}, err_o, 0);
         check(done_cnt == 1, "R8", {name, " done width"}, done_cnt, 1);
         check(int'(tap_o) == exp_t, "R6", {name, " chosen tap"}, tap_o, exp_t);
         check(tap_log[LIM] == exp_t, "R5", {name, " final tap applied"}, tap_log[LIM], exp_t);
      end
   endtask

   task automatic fill(input bit p, input int l);
      for (int i = 0; i < 64; i++) begin pass_pat[i] = p; lat_pat[i] = l; end
   endtask

   initial begin
      void'($urandom(32'h1F2E3D4C));
      fill(1'b0, 0);
      repeat (3) @(negedge clk);
      check(!tap_apply_o && !chk_req_o && !done_o && !err_o, "R11", "outputs low in reset",
            {tap_apply_o, chk_req_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!tap_apply_o && !done_o && !err_o, "R11", "idle after reset",
            {tap_apply_o, done_o, err_o}, 0);

      fill(1'b1, 0);
      run_case("all_pass", 1'b0);                 // centre 39-20=19

      fill(1'b0, 1);
      run_case("none_pass", 1'b0);                // R7
      repeat (20) @(negedge clk);
      check(err_o == 1'b1, "R9", "err held while idle", err_o, 1);

      fill(1'b0, 2);                              // R5 tie: earliest window wins -> 7
      for (int i = 5; i < 10; i++) pass_pat[i] = 1'b1;
      for (int i = 20; i < 25; i++) pass_pat[i] = 1'b1;
      run_case("equal_windows", 1'b0);

      fill(1'b0, 1);                              // R3 boundary: 17 ok, 18 times out -> 24
      for (int i = 10; i <= 30; i++) pass_pat[i] = 1'b1;
      lat_pat[17] = TMO - 1;
      lat_pat[18] = TMO;
      run_case("timeout_split", 1'b0);

      fill(1'b0, 0);                              // only 39 inside range
      for (int i = 39; i < 64; i++) pass_pat[i] = 1'b1;
      run_case("edge_tap", 1'b0);

      fill(1'b1, 1);
      run_case("mid_start", 1'b1);                // R10

      fill(1'b1, 0);
      final_stall = 1'b1;
      run_case("final_stall", 1'b0);              // R12
      final_stall = 1'b0;

      for (int r = 0; r < 20; r++) begin
         for (int i = 0; i < 64; i++) begin
            pass_pat[i] = ($urandom % 10) < 7;
            lat_pat[i]  = ($urandom % 8 == 0) ? int'($urandom % (TMO + 4)) : int'($urandom % 4);
         end
         run_case($sformatf("rand%0d", r), 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule